// File: doc/BRIEF.md
# Composite Sync Separator and Detector

This block is the digital front end for a display monitor's sync inputs, clocked by a fast system clock. It takes two raw inputs: one that carries horizontal sync or composite sync, and one that carries a separate vertical sync. Each input passes through a two-stage synchronizer. The block then works out the polarity of each input, so either sense of sync is accepted, and turns both into active-high pulses.

The horizontal path measures the time between accepted leading edges to get the line period. It classifies every pulse by width against a quarter of that period. Leading edges that come early in a line are dropped. This removes half-line equalizing pulses, so the phase comparator downstream gets exactly one edge per line. In composite mode, wide pulses mark the frame sync. The block extracts a vertical pulse from them and holds an inhibit window for the phase comparator while they last.

Three sticky presence flags record what has been seen: horizontal present, vertical present, and vertical extracted from composite. A controller clears them with a refresh strobe and reads them again one frame time later.

Top module: `csync_separator`

## Requirements
- R1: `hPolNeg` and `vPolNeg` give the polarity of each input, where 1 means active low. Each input is sampled for a fixed window of `WIN_LEN` clocks. A window whose high-sample count times two exceeds `WIN_LEN` votes negative. The output takes a vote only when two consecutive windows agree. Both polarity outputs reset to 0.
- R2: The normalised vertical input is the synchronized vertical input XOR `vPolNeg`. When `sepMode` = 1, `vOut` equals this normalised vertical input.
- R3: `hOut` is a one-clock pulse, asserted one clock after the leading edge of an accepted horizontal pulse is seen on the normalised signal. The line period is the clock count between consecutive accepted leading edges.
- R4: While the line period is valid, a leading edge that arrives before three quarters of the period has elapsed since the last accepted edge is dropped and produces no `hOut`. Half-line equalizing pulses therefore add no `hOut` pulses.
- R5: A pulse counts as a line pulse when all of the following hold: its width is at least `MIN_W` clocks, four times its width is at most the line period, and the period is valid. A line pulse sets `hDet`.
- R6: A wide pulse is one where four times its width exceeds the valid period. In composite mode (`sepMode` = 0), the trailing edge of a wide pulse raises `vOut` and `pcInhibit`, and the first wide pulse of a run sets `vxDet`. Both outputs fall at the trailing edge of the next line pulse.
- R7: With `sepMode` = 1, no vertical pulse is extracted, `pcInhibit` stays low and `vxDet` is never set.
- R8: A `refresh` strobe clears `hDet`, `vDet` and `vxDet` on the next clock. The clear wins over any set in the same cycle.
- R9: If the leading-edge counter saturates at its all-ones value, `hDet` is cleared and the period becomes invalid. A period of zero is never treated as valid.
- R10: A rising edge of the normalised vertical input sets `vDet` in either mode.
- R11: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hvIn | input | 1 | Raw horizontal or composite sync |
| vIn | input | 1 | Raw separate vertical sync |
| sepMode | input | 1 | 1 = separate H and V, 0 = composite |
| refresh | input | 1 | One-clock strobe that clears the presence flags |
| hOut | output | 1 | Cleaned horizontal pulse, one clock per line |
| vOut | output | 1 | Vertical sync, active high |
| pcInhibit | output | 1 | Phase comparator inhibit window |
| hPolNeg | output | 1 | Horizontal input is active low |
| vPolNeg | output | 1 | Vertical input is active low |
| hDet | output | 1 | Horizontal sync present (sticky) |
| vDet | output | 1 | Vertical sync present (sticky) |
| vxDet | output | 1 | Vertical extracted from composite (sticky) |

## Verification
The assertions assume inputs that hold each level for at least two clocks. This keeps the normalised signal from producing back-to-back leading edges. They also assume that `refresh` and `sepMode` are clean synchronous levels. The stimulus changes every input only on the falling clock edge. It builds pulses from whole-cycle widths, all of them `MIN_W` or longer. It keeps the line period far below the counter limit, except in the one deliberate silence used to force saturation.

// File: rtl/csync_pkg.sv
package csync_pkg;

  // strobes from control into the counting datapath
  typedef struct packed {
    logic widthStart;
    logic widthGrow;
    logic acceptEdge;
  } dpStrobe_t;

  // classification results back to control
  typedef struct packed {
    logic gateOpen;
    logic periodOk;
    logic lineWidth;
    logic wideWidth;
    logic sinceFull;
  } dpStatus_t;

endpackage

// File: rtl/csync_input_cond.sv
module csync_input_cond #(
  parameter int WIN_LEN = 2048
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic polNeg,
  output logic normOut
);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int HI_W  = WIN_W + 1;

  logic             meta, samp;
  logic [WIN_W-1:0] winCnt;
  logic [HI_W-1:0]  hiCnt, hiTot;
  logic             lastCand, cand, winEnd;

  assign winEnd = (winCnt == WIN_W'(WIN_LEN - 1));
  assign hiTot  = hiCnt + HI_W'(samp);
  assign cand   = ({hiTot, 1'b0} > (HI_W + 1)'(WIN_LEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta     <= 1'b0;
      samp     <= 1'b0;
      winCnt   <= '0;
      hiCnt    <= '0;
      lastCand <= 1'b0;
      polNeg   <= 1'b0;
    end else begin
      meta <= rawIn;
      samp <= meta;
      if (winEnd) begin
        winCnt   <= '0;
        hiCnt    <= '0;
        lastCand <= cand;
        if (cand == lastCand) polNeg <= cand;
      end else begin
        winCnt <= winCnt + 1'b1;
        hiCnt  <= hiTot;
      end
    end
  end

  assign normOut = samp ^ polNeg;

  // R1: the polarity decision moves only at the close of a window
  a_r1_pol_at_window_end: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(polNeg) |-> $past(winEnd));

endmodule

// File: rtl/csync_datapath.sv
module csync_datapath import csync_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int MIN_W = 88
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output dpStatus_t status
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int EXT_W = CNT_W + 2;

  logic [CNT_W-1:0] wCnt, since, linePeriod;
  logic             pValid;
  logic [EXT_W-1:0] w4, since4, perE, per3;

  assign w4     = {wCnt, 2'b00};
  assign since4 = {since, 2'b00};
  assign perE   = EXT_W'(linePeriod);
  assign per3   = perE * EXT_W'(3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wCnt       <= '0;
      since      <= CNT_MAX;
      linePeriod <= '0;
      pValid     <= 1'b0;
    end else begin
      if (strobe.widthStart)
        wCnt <= CNT_W'(1);
      else if (strobe.widthGrow && wCnt != CNT_MAX)
        wCnt <= wCnt + 1'b1;

      if (strobe.acceptEdge) begin
        linePeriod <= since;
        pValid     <= (since != '0) && (since != CNT_MAX);
        since      <= CNT_W'(1);
      end else if (since == CNT_MAX) begin
        pValid <= 1'b0;
      end else begin
        since <= since + 1'b1;
      end
    end
  end

  assign status.gateOpen  = (since4 >= per3);
  assign status.periodOk  = pValid;
  assign status.lineWidth = (wCnt >= CNT_W'(MIN_W)) && (w4 <= perE);
  assign status.wideWidth = (w4 > perE);
  assign status.sinceFull = (since == CNT_MAX);

  // R9: a valid period is never zero
  a_r9_period_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    pValid |-> (linePeriod != '0));

endmodule

// File: rtl/csync_control.sv
module csync_control import csync_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hNorm,
  input  logic      vNorm,
  input  logic      sepMode,
  input  logic      refresh,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      hOut,
  output logic      vOut,
  output logic      pcInhibit,
  output logic      hDet,
  output logic      vDet,
  output logic      vxDet
);
  logic hPrev, vPrev, vAct;
  logic lead, trail, isLine, isWide, vLead, newVx;

  assign lead   = hNorm & ~hPrev;
  assign trail  = ~hNorm & hPrev;
  assign vLead  = vNorm & ~vPrev;
  assign isLine = trail & status.periodOk & status.lineWidth;
  assign isWide = trail & status.periodOk & status.wideWidth;
  assign newVx  = ~sepMode & isWide & ~vAct;

  assign strobe.widthStart = lead;
  assign strobe.widthGrow  = hNorm;
  assign strobe.acceptEdge = lead & (~status.periodOk | status.gateOpen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev <= 1'b0;
      vPrev <= 1'b0;
      vAct  <= 1'b0;
      hOut  <= 1'b0;
      hDet  <= 1'b0;
      vDet  <= 1'b0;
      vxDet <= 1'b0;
    end else begin
      hPrev <= hNorm;
      vPrev <= vNorm;
      hOut  <= strobe.acceptEdge;

      if (~sepMode & isWide)     vAct <= 1'b1;
      else if (isLine | sepMode) vAct <= 1'b0;

      if (refresh)               hDet <= 1'b0;
      else if (status.sinceFull) hDet <= 1'b0;
      else if (isLine)           hDet <= 1'b1;

      if (refresh)    vDet <= 1'b0;
      else if (vLead) vDet <= 1'b1;

      if (refresh)    vxDet <= 1'b0;
      else if (newVx) vxDet <= 1'b1;
    end
  end

  assign vOut      = sepMode ? vNorm : vAct;
  assign pcInhibit = vAct;

  // R3: each accepted edge gives exactly one clock of hOut
  a_r3_hout_single: assert property (@(posedge clk) disable iff (!rstN)
    hOut |=> !hOut);
  // R8: refresh empties every presence flag
  a_r8_refresh_clears: assert property (@(posedge clk) disable iff (!rstN)
    refresh |=> (!hDet && !vDet && !vxDet));
  // R7: separate mode never holds the inhibit window
  a_r7_no_inhibit_sep: assert property (@(posedge clk) disable iff (!rstN)
    $past(sepMode) |-> !pcInhibit);
  // R6: extraction flag rises only from composite mode
  a_r6_vx_from_composite: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vxDet) |-> !$past(sepMode));

endmodule

// File: rtl/csync_separator.sv
module csync_separator import csync_pkg::*; #(
  parameter int CNT_W   = 16,
  parameter int MIN_W   = 88,
  parameter int WIN_LEN = 2048
) (
  input  logic clk,
  input  logic rstN,
  input  logic hvIn,
  input  logic vIn,
  input  logic sepMode,
  input  logic refresh,
  output logic hOut,
  output logic vOut,
  output logic pcInhibit,
  output logic hPolNeg,
  output logic vPolNeg,
  output logic hDet,
  output logic vDet,
  output logic vxDet
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] rawVec, polVec, normVec;
  dpStrobe_t strobe;
  dpStatus_t status;

  assign rawVec = {vIn, hvIn};

  for (genvar g = 0; g < N_IN; g++) begin : g_cond
    csync_input_cond #(.WIN_LEN(WIN_LEN)) i_cond (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawVec[g]),
      .polNeg  (polVec[g]),
      .normOut (normVec[g])
    );
  end

  assign hPolNeg = polVec[0];
  assign vPolNeg = polVec[1];

  csync_datapath #(.CNT_W(CNT_W), .MIN_W(MIN_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .status (status)
  );

  csync_control i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .hNorm     (normVec[0]),
    .vNorm     (normVec[1]),
    .sepMode   (sepMode),
    .refresh   (refresh),
    .status    (status),
    .strobe    (strobe),
    .hOut      (hOut),
    .vOut      (vOut),
    .pcInhibit (pcInhibit),
    .hDet      (hDet),
    .vDet      (vDet),
    .vxDet     (vxDet)
  );

endmodule

// File: tb/test_csync_separator.sv
`timescale 1ns/1ps
module test_csync_separator;
  localparam int CNT_W = 12;
  localparam int MIN_W = 8;
  localparam int WIN   = 512;
  localparam int PER   = 200;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 0, rstN = 0, hvIn = 0, vIn = 0, sepMode = 0, refresh = 0;
  logic hOut, vOut, pcInhibit, hPolNeg, vPolNeg, hDet, vDet, vxDet;

  int vectors = 0, fails = 0, hCount = 0;
  bit done = 0;

  always #4 clk = ~clk;

  csync_separator #(.CNT_W(CNT_W), .MIN_W(MIN_W), .WIN_LEN(WIN)) i_csync_separator (
    .clk(clk), .rstN(rstN), .hvIn(hvIn), .vIn(vIn), .sepMode(sepMode),
    .refresh(refresh), .hOut(hOut), .vOut(vOut), .pcInhibit(pcInhibit),
    .hPolNeg(hPolNeg), .vPolNeg(vPolNeg), .hDet(hDet), .vDet(vDet), .vxDet(vxDet));

  // behavioural reference model
  int mA[2], mS[2], mWin[2], mHi[2], mLast[2], mPol[2];
  int mHPrev, mVPrev, mW, mSince, mPer, mPv, mVAct, mHOut, mHDet, mVDet, mVxDet;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mA[i] = 0; mS[i] = 0; mWin[i] = 0; mHi[i] = 0; mLast[i] = 0; mPol[i] = 0;
      end
      mHPrev = 0; mVPrev = 0; mW = 0; mSince = MAXC; mPer = 0; mPv = 0;
      mVAct = 0; mHOut = 0; mHDet = 0; mVDet = 0; mVxDet = 0;
    end else begin
      int nH, nV, lead, trail, full, acc, isL, isW, vLead;
      nH    = mS[0] ^ mPol[0];
      nV    = mS[1] ^ mPol[1];
      lead  = nH && !mHPrev;
      trail = !nH && mHPrev;
      full  = (mSince == MAXC);
      acc   = lead && (!mPv || (4 * mSince >= 3 * mPer));
      isL   = trail && mPv && (mW >= MIN_W) && (4 * mW <= mPer);
      isW   = trail && mPv && (4 * mW > mPer);
      vLead = nV && !mVPrev;
      if (refresh) mVxDet = 0; else if (!sepMode && isW && !mVAct) mVxDet = 1;
      if (refresh) mHDet = 0; else if (full) mHDet = 0; else if (isL) mHDet = 1;
      if (refresh) mVDet = 0; else if (vLead) mVDet = 1;
      if (!sepMode && isW) mVAct = 1; else if (isL || sepMode) mVAct = 0;
      mHOut = acc;
      if (lead) mW = 1; else if (nH && mW != MAXC) mW = mW + 1;
      if (acc) begin
        mPer = mSince; mPv = (mSince != 0 && !full); mSince = 1;
      end else if (full) mPv = 0;
      else mSince = mSince + 1;
      mHPrev = nH; mVPrev = nV;
      for (int i = 0; i < 2; i++) begin
        if (mWin[i] == WIN - 1) begin
          int cand;
          cand = (2 * (mHi[i] + mS[i]) > WIN);
          if (cand == mLast[i]) mPol[i] = cand;
          mLast[i] = cand; mHi[i] = 0; mWin[i] = 0;
        end else begin
          mHi[i] = mHi[i] + mS[i]; mWin[i] = mWin[i] + 1;
        end
      end
      mS[0] = mA[0]; mS[1] = mA[1];
      mA[0] = hvIn; mA[1] = vIn;
    end
  end

  task automatic cmp(input string tag, input string nm, input logic act, input int exp);
    vectors++;
    if (act !== exp[0]) begin
      fails++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, nm, act, exp[0], $time);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      if (hOut === 1'b1) hCount++;
      cmp("R3", "hOut", hOut, mHOut);
      cmp("R2", "vOut", vOut, sepMode ? (mS[1] ^ mPol[1]) : mVAct);
      cmp("R6", "pcInhibit", pcInhibit, mVAct);
      cmp("R1", "hPolNeg", hPolNeg, mPol[0]);
      cmp("R1", "vPolNeg", vPolNeg, mPol[1]);
      cmp("R5", "hDet", hDet, mHDet);
      cmp("R10", "vDet", vDet, mVDet);
      cmp("R6", "vxDet", vxDet, mVxDet);
    end
  end

  task automatic lines(input int n, input int hw, input bit hNeg,
                       input int vFrom, input int vTo, input bit vNeg);
    for (int l = 0; l < n; l++)
      for (int c = 0; c < PER; c++) begin
        @(negedge clk);
        hvIn = (c < hw) ^ hNeg;
        vIn  = (l >= vFrom && l < vTo) ^ vNeg;
      end
  endtask

  task automatic eq_lines(input int n, input bit hNeg);
    for (int l = 0; l < n; l++)
      for (int c = 0; c < PER; c++) begin
        @(negedge clk);
        hvIn = ((c % (PER / 2)) < MIN_W) ^ hNeg;
      end
  endtask

  task automatic do_refresh;
    @(negedge clk); refresh = 1;
    @(negedge clk); refresh = 0;
    chk("R8 hDet", hDet, 0);
    chk("R8 vDet", vDet, 0);
    chk("R8 vxDet", vxDet, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int h0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 hOut", hOut, 0);
    chk("R11 vOut", vOut, 0);
    chk("R11 pcInhibit", pcInhibit, 0);
    chk("R11 pol", {hPolNeg, vPolNeg}, 0);
    chk("R11 flags", {hDet, vDet, vxDet}, 0);
    rstN = 1;
    sepMode = 1;
    lines(12, 16, 0, 5, 7, 0);
    h0 = hCount;
    lines(10, 16, 0, 99, 99, 0);
    chk("R3 hOut per line", hCount - h0, 10);
    chk("R5 hDet", hDet, 1);
    chk("R10 vDet", vDet, 1);
    chk("R1 positive H", hPolNeg, 0);
    do_refresh();
    // composite, positive
    sepMode = 0;
    lines(6, 16, 0, 99, 99, 0);
    h0 = hCount;
    eq_lines(6, 0);
    chk("R4 equalizing dropped", hCount - h0, 6);
    lines(3, 80, 0, 99, 99, 0);
    chk("R6 inhibit held", pcInhibit, 1);
    chk("R6 vOut extracted", vOut, 1);
    eq_lines(6, 0);
    chk("R6 inhibit released", pcInhibit, 0);
    lines(4, 16, 0, 99, 99, 0);
    chk("R6 vxDet", vxDet, 1);
    // composite, negative
    do_refresh();
    lines(14, 16, 1, 99, 99, 0);
    chk("R1 negative H", hPolNeg, 1);
    eq_lines(6, 1);
    lines(3, 80, 1, 99, 99, 0);
    eq_lines(6, 1);
    lines(4, 16, 1, 99, 99, 0);
    chk("R6 vxDet negative", vxDet, 1);
    // separate mode with wide pulses: nothing extracted
    sepMode = 1;
    do_refresh();
    lines(4, 80, 1, 99, 99, 0);
    chk("R7 no inhibit", pcInhibit, 0);
    chk("R7 no vxDet", vxDet, 0);
    // negative vertical
    lines(14, 16, 1, 2, 3, 1);
    chk("R1 negative V", vPolNeg, 1);
    chk("R2 vOut idle", vOut, 0);
    // silence: counter saturates
    hvIn = 1;
    repeat (MAXC + 200) @(negedge clk);
    chk("R9 hDet cleared", hDet, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule